// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Keyed Write Protection

This block is a watchdog for a host that talks to it over a plain register write/read port. Two countdown stages run one after the other. The first stage counts down from its own preload value, and when it runs out it can flag an interrupt. The block then loads the second stage, which counts down from a separate preload. When the second stage runs out, the block records a sticky timeout flag and, if configured to, drives a fixed-length system reset request. A reload command sends the block back to the first stage with a fresh preload. A host that is alive therefore keeps issuing reloads before the first stage expires.

Writes to the two preload registers and to the reload register are guarded. The host must first write the key pair 0x80 and then 0x86 to the reload register. That opens the guard for exactly one protected write, after which it closes again. A control register holds the enable bit, a sticky lock bit and a mode bit. The mode bit turns the block into a plain periodic timer that never reaches the second stage. A configuration register picks the prescale rate and the interrupt style and gates the reset request.

Top module: `wdt2_dual_stage`

## Requirements
- R1: After reset the stage-1 and stage-2 preloads read their parameter defaults, and interrupt status, timeout flag and control all read 0. Configuration reads 0x3 (slow rate, no interrupt, reset request off). The count register reads the stage-1 default, both outputs are low, and counting is disabled.
- R2: A write of 0x0080 and then, as the very next bus write, 0x0086 to the reload register (offset 0x0C) opens the guard. The next write to offset 0x00, 0x04 or 0x0C is accepted and closes the guard again, so a second protected write without a new key pair is ignored.
- R3: A protected write made while the guard is closed has no effect. After 0x0080, any bus write other than 0x0086 to the reload register (including a write to another register) returns the key detector to idle.
- R4: An accepted reload write with bit 8 set puts the block in stage 1 and loads the stage-1 preload into the counter. Repeating this faster than stage 1 expires keeps both the interrupt and the reset request from ever occurring.
- R5: With tick period T, stage 1 lasts P1+1 ticks and stage 2 lasts P2+1 ticks. Stage-1 expiry sets interrupt status bit 0 and loads stage 2. The second expiry comes exactly (P2+1)·T cycles after the first.
- R6: Stage-2 expiry sets the timeout flag (reload register bit 9) and restarts stage 1. If configuration bit 5 is set, it also drives the reset request high for exactly RST_CYCLES cycles; with bit 5 clear the request stays low.
- R7: The timeout flag is cleared only by an accepted reload write with bits 9 and 8 both set. Bit 9 alone leaves it set.
- R8: Control bit 0 (lock) is sticky until reset. While it is set, control bit 1 (enable) cannot be cleared.
- R9: While enable is 0 the counter and the stage do not change.
- R10: Configuration bit 2 = 0 gives one tick every 2^SLOW_LOG2 cycles; bit 2 = 1 gives one tick every 2^FAST_LOG2 cycles.
- R11: Configuration bits 1:0 pick the interrupt style: 00 or 10 level (follows status bit 0), 01 a one-cycle pulse per stage-1 expiry, 11 none. Writing 1 to bit 0 at offset 0x08 clears status.
- R12: With control bit 2 set (timer mode), stage 1 reloads itself on expiry every (P1+1)·T cycles and stage 2, the timeout flag and the reset request are never reached.
- R13: The count register at offset 0x18 returns the live counter in its low bits and the active stage in bit 31 (1 = stage 2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address; only word-aligned writes are decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | Stage-1 interrupt in the configured style |
| sys_rst_req_o | output | 1 | System reset request pulse |

## Verification
The bench builds the block with SLOW_LOG2 = 6, FAST_LOG2 = 3, stage preload defaults of 7 and 9 and a 16-cycle reset pulse. With these values one tick comes every 64 or 8 cycles. Full stage-1 to stage-2 chains, the exact inter-stage gap, periodic timer-mode intervals at both rates, and the keep-alive race against stage-1 expiry all fit within a few hundred cycles each. The unlock misuse cases and the lock stickiness need no waiting at all.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
    localparam int ADDR_W = 5;

    // Word index of each register (byte offset >> 2)
    localparam logic [2:0] IDX_PRE1   = 3'd0;
    localparam logic [2:0] IDX_PRE2   = 3'd1;
    localparam logic [2:0] IDX_INTST  = 3'd2;
    localparam logic [2:0] IDX_RELOAD = 3'd3;
    localparam logic [2:0] IDX_CTRL   = 3'd4;
    localparam logic [2:0] IDX_CFG    = 3'd5;
    localparam logic [2:0] IDX_COUNT  = 3'd6;

    localparam logic [15:0] KEY_FIRST  = 16'h0080;
    localparam logic [15:0] KEY_SECOND = 16'h0086;

    localparam int RELOAD_CMD_BIT = 8;
    localparam int FLAG_CLR_BIT   = 9;

    typedef enum logic [1:0] {
        GUARD_IDLE = 2'd0,
        GUARD_HALF = 2'd1,
        GUARD_OPEN = 2'd2
    } guard_state_e;

    typedef enum logic [1:0] {
        IRQ_LEVEL     = 2'b00,
        IRQ_PULSE     = 2'b01,
        IRQ_LEVEL_ALT = 2'b10,
        IRQ_NONE      = 2'b11
    } irq_kind_e;
endpackage

// File: rtl/wdt2_prescaler.sv
module wdt2_prescaler #(
    parameter int SLOW_LOG2 = 15,
    parameter int FAST_LOG2 = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_sel,
    output logic tick
);
    logic [SLOW_LOG2-1:0] div_q, div_d;

    always_comb begin
        div_d = div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign tick = fast_sel ? (&div_q[FAST_LOG2-1:0]) : (&div_q);

    // R10: ticks are single-cycle strobes at either rate
    a_r10_tick_isolated: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
endmodule

// File: rtl/wdt2_guard.sv
module wdt2_guard
    import wdt2_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        any_wr,
    input  logic        key_wr,
    input  logic [15:0] key_val,
    input  logic        prot_wr,
    output logic        open_o
);
    guard_state_e st_q, st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            GUARD_IDLE: if (key_wr && key_val == KEY_FIRST) st_d = GUARD_HALF;
            GUARD_HALF: if (any_wr)
                            st_d = (key_wr && key_val == KEY_SECOND) ? GUARD_OPEN : GUARD_IDLE;
            GUARD_OPEN: if (prot_wr) st_d = GUARD_IDLE;
            default:    st_d = GUARD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= GUARD_IDLE;
        else        st_q <= st_d;
    end

    assign open_o = (st_q == GUARD_OPEN);

    // R2: the guard opens only right after the second key was written
    a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open_o) |-> $past(key_wr && key_val == KEY_SECOND));
    // R2: one protected write consumes the opening
    a_r2_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
        (open_o && prot_wr) |=> !open_o);
endmodule

// File: rtl/wdt2_stages.sv
module wdt2_stages #(
    parameter int CNT_W     = 20,
    parameter int PRE1_INIT = 15360
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             timer_mode,
    input  logic             reload,
    input  logic [CNT_W-1:0] pre1,
    input  logic [CNT_W-1:0] pre2,
    output logic [CNT_W-1:0] count_o,
    output logic             in_stage2_o,
    output logic             exp1_o,
    output logic             exp2_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             s2;
    } stage_t;

    stage_t q, d;
    logic   step, at_zero;

    always_comb begin
        step    = run && tick;
        at_zero = (q.cnt == '0);
        exp1_o  = step && !reload && !q.s2 && at_zero;
        exp2_o  = step && !reload && q.s2 && at_zero;
        d = q;
        if (reload) begin
            d.cnt = pre1;
            d.s2  = 1'b0;
        end else if (step) begin
            if (!at_zero) begin
                d.cnt = q.cnt - 1'b1;
            end else if (!q.s2) begin
                if (timer_mode) begin
                    d.cnt = pre1;
                end else begin
                    d.s2  = 1'b1;
                    d.cnt = pre2;
                end
            end else begin
                d.s2  = 1'b0;
                d.cnt = pre1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.cnt <= CNT_W'(PRE1_INIT);
            q.s2  <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign count_o     = q.cnt;
    assign in_stage2_o = q.s2;

    // R9: nothing moves while disabled and no reload arrives
    a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !reload) |=> ($stable(count_o) && $stable(in_stage2_o)));
    // R5: a tick on a nonzero count removes exactly one
    a_r5_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && !reload && count_o != '0) |=> (count_o + 1'b1) == $past(count_o));
    // R12: in timer mode stage 1 never hands over to stage 2
    a_r12_no_stage2: assert property (@(posedge clk) disable iff (!rst_n)
        (timer_mode && !in_stage2_o) |=> !in_stage2_o);
endmodule

// File: rtl/wdt2_dual_stage.sv
module wdt2_dual_stage
    import wdt2_pkg::*;
#(
    parameter int CNT_W      = 20,
    parameter int SLOW_LOG2  = 15,
    parameter int FAST_LOG2  = 5,
    parameter int RST_CYCLES = 16,
    parameter int PRE1_INIT  = 15360,
    parameter int PRE2_INIT  = 15360
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     bus_we,
    input  logic [wdt2_pkg::ADDR_W-1:0] bus_addr,
    input  logic [31:0]              bus_wdata,
    output logic [31:0]              bus_rdata,
    output logic                     irq_o,
    output logic                     sys_rst_req_o
);
    localparam int RC_W = $clog2(RST_CYCLES + 1);

    typedef struct packed {
        logic [CNT_W-1:0] pre1;
        logic [CNT_W-1:0] pre2;
        logic             int_flag;
        logic             timeout;
        logic             lock;
        logic             en;
        logic             tmode;
        logic             rst_en;
        logic             fast;
        irq_kind_e        itype;
        logic             irq;
        logic [RC_W-1:0]  rst_cnt;
    } regs_t;

    regs_t q, d;

    logic [2:0]       idx;
    logic             wr, prot_wr, guard_open, accept, reload_cmd;
    logic             tick, exp1, exp2, in_s2;
    logic [CNT_W-1:0] count;

    always_comb begin
        idx        = bus_addr[ADDR_W-1:2];
        wr         = bus_we && (bus_addr[1:0] == 2'b00);
        prot_wr    = wr && (idx == IDX_PRE1 || idx == IDX_PRE2 || idx == IDX_RELOAD);
        accept     = guard_open && prot_wr;
        reload_cmd = accept && (idx == IDX_RELOAD) && bus_wdata[RELOAD_CMD_BIT];
    end

    wdt2_prescaler #(
        .SLOW_LOG2 (SLOW_LOG2),
        .FAST_LOG2 (FAST_LOG2)
    ) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_sel (q.fast),
        .tick     (tick)
    );

    wdt2_guard u_guard (
        .clk     (clk),
        .rst_n   (rst_n),
        .any_wr  (bus_we),
        .key_wr  (wr && idx == IDX_RELOAD),
        .key_val (bus_wdata[15:0]),
        .prot_wr (prot_wr),
        .open_o  (guard_open)
    );

    wdt2_stages #(
        .CNT_W     (CNT_W),
        .PRE1_INIT (PRE1_INIT)
    ) u_stages (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (q.en),
        .tick        (tick),
        .timer_mode  (q.tmode),
        .reload      (reload_cmd),
        .pre1        (q.pre1),
        .pre2        (q.pre2),
        .count_o     (count),
        .in_stage2_o (in_s2),
        .exp1_o      (exp1),
        .exp2_o      (exp2)
    );

    // Next-state for all registers
    always_comb begin
        d = q;
        if (accept && idx == IDX_PRE1) d.pre1 = bus_wdata[CNT_W-1:0];
        if (accept && idx == IDX_PRE2) d.pre2 = bus_wdata[CNT_W-1:0];

        if (reload_cmd && bus_wdata[FLAG_CLR_BIT]) d.timeout = 1'b0;
        if (exp2) d.timeout = 1'b1;

        if (wr && idx == IDX_INTST && bus_wdata[0]) d.int_flag = 1'b0;
        if (exp1) d.int_flag = 1'b1;

        if (wr && idx == IDX_CTRL) begin
            d.lock  = q.lock | bus_wdata[0];
            d.en    = q.lock ? (q.en | bus_wdata[1]) : bus_wdata[1];
            d.tmode = bus_wdata[2];
        end

        if (wr && idx == IDX_CFG) begin
            d.rst_en = bus_wdata[5];
            d.fast   = bus_wdata[2];
            d.itype  = irq_kind_e'(bus_wdata[1:0]);
        end

        if (exp2 && q.rst_en)     d.rst_cnt = RC_W'(RST_CYCLES);
        else if (q.rst_cnt != '0) d.rst_cnt = q.rst_cnt - 1'b1;

        unique case (q.itype)
            IRQ_NONE:  d.irq = 1'b0;
            IRQ_PULSE: d.irq = exp1;
            default:   d.irq = d.int_flag;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.pre1     <= CNT_W'(PRE1_INIT);
            q.pre2     <= CNT_W'(PRE2_INIT);
            q.int_flag <= 1'b0;
            q.timeout  <= 1'b0;
            q.lock     <= 1'b0;
            q.en       <= 1'b0;
            q.tmode    <= 1'b0;
            q.rst_en   <= 1'b0;
            q.fast     <= 1'b0;
            q.itype    <= IRQ_NONE;
            q.irq      <= 1'b0;
            q.rst_cnt  <= '0;
        end else begin
            q <= d;
        end
    end

    // Register read mux
    always_comb begin
        bus_rdata = '0;
        unique case (idx)
            IDX_PRE1:   bus_rdata[CNT_W-1:0] = q.pre1;
            IDX_PRE2:   bus_rdata[CNT_W-1:0] = q.pre2;
            IDX_INTST:  bus_rdata[0] = q.int_flag;
            IDX_RELOAD: bus_rdata[FLAG_CLR_BIT] = q.timeout;
            IDX_CTRL:   bus_rdata[2:0] = {q.tmode, q.en, q.lock};
            IDX_CFG:    begin
                            bus_rdata[5]   = q.rst_en;
                            bus_rdata[2]   = q.fast;
                            bus_rdata[1:0] = q.itype;
                        end
            IDX_COUNT:  begin
                            bus_rdata[CNT_W-1:0] = count;
                            bus_rdata[31]        = in_s2;
                        end
            default:    bus_rdata = '0;
        endcase
    end

    assign irq_o         = q.irq;
    assign sys_rst_req_o = (q.rst_cnt != '0);

    // R8: lock never drops, and a locked enable never drops
    a_r8_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        q.lock |=> q.lock);
    a_r8_enable_held: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lock && q.en) |=> q.en);
    // R6: a reset request always comes with the timeout flag
    a_r6_req_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst_req_o) |-> q.timeout);
    // R7: the flag only falls after an accepted reload carrying the clear bit
    a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.timeout) |-> $past(reload_cmd && bus_wdata[FLAG_CLR_BIT]));
    // R3: a preload changes only through an accepted protected write
    a_r3_no_stray_preload: assert property (@(posedge clk) disable iff (!rst_n)
        (q.pre1 != $past(q.pre1)) |-> $past(accept && idx == IDX_PRE1));
    // R11: style "none" keeps the interrupt line quiet
    a_r11_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.itype) == IRQ_NONE) |-> !irq_o);
endmodule

// File: tb/tb_wdt2_dual_stage.sv
module tb_wdt2_dual_stage;
    localparam int P_SLOW = 6;
    localparam int P_FAST = 3;
    localparam int T_SLOW = 1 << P_SLOW;
    localparam int T_FAST = 1 << P_FAST;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, sys_rst_req_o;

    int checks = 0;
    int fails = 0;
    int irq_hi = 0;
    int rst_hi = 0;

    wdt2_dual_stage #(
        .CNT_W(20), .SLOW_LOG2(P_SLOW), .FAST_LOG2(P_FAST),
        .RST_CYCLES(16), .PRE1_INIT(7), .PRE2_INIT(9)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .sys_rst_req_o(sys_rst_req_o)
    );

    always #2.5 clk = ~clk;

    always @(negedge clk) begin
        if (irq_o) irq_hi++;
        if (sys_rst_req_o) rst_hi++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] v);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = v;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic unlocked_wr(input logic [4:0] a, input logic [31:0] v);
        wr(5'h0C, 32'h80);
        wr(5'h0C, 32'h86);
        wr(a, v);
    endtask

    task automatic wait_irq(output int n);
        n = 0;
        while (!irq_o && n < 2000) begin @(negedge clk); n++; end
    endtask

    task automatic t_reset;
        logic [31:0] v;
        rd(5'h00, v); chk("R1 pre1", v, 7);
        rd(5'h04, v); chk("R1 pre2", v, 9);
        rd(5'h08, v); chk("R1 status", v, 0);
        rd(5'h0C, v); chk("R1 flag", v, 0);
        rd(5'h10, v); chk("R1 ctrl", v, 0);
        rd(5'h14, v); chk("R1 cfg", v, 3);
        rd(5'h18, v); chk("R1 R13 count", v, 7);
        chk("R1 outputs", {30'd0, irq_o, sys_rst_req_o}, 0);
    endtask

    task automatic t_guard;
        logic [31:0] v;
        wr(5'h00, 32'h55);
        rd(5'h00, v); chk("R3 no key", v, 7);
        wr(5'h0C, 32'h80); wr(5'h0C, 32'h44); wr(5'h0C, 32'h86); wr(5'h00, 32'h3);
        rd(5'h00, v); chk("R3 wrong second key", v, 7);
        wr(5'h0C, 32'h80); wr(5'h14, 32'h3); wr(5'h0C, 32'h86); wr(5'h00, 32'h3);
        rd(5'h00, v); chk("R3 foreign write breaks", v, 7);
        unlocked_wr(5'h00, 32'h3);
        rd(5'h00, v); chk("R2 accepted", v, 3);
        wr(5'h00, 32'h4);
        rd(5'h00, v); chk("R2 one shot", v, 3);
        unlocked_wr(5'h04, 32'h5);
        rd(5'h04, v); chk("R2 pre2", v, 5);
    endtask

    task automatic t_reload_hold;
        logic [31:0] v;
        rd(5'h18, v); chk("R13 old count", v, 7);
        unlocked_wr(5'h0C, 32'h100);
        rd(5'h18, v); chk("R4 reload loads pre1", v, 3);
        repeat (50) @(negedge clk);
        rd(5'h18, v); chk("R9 disabled holds", v, 3);
    endtask

    task automatic t_chain;
        logic [31:0] v;
        int n;
        wr(5'h14, 32'h24);
        wr(5'h10, 32'h2);
        wait_irq(n);
        chk_range("R5 stage1 length", n, 3 * T_FAST, 4 * T_FAST + 1);
        rd(5'h18, v); chk("R13 R5 stage2 loaded", v, 32'h8000_0005);
        n = 0;
        while (!sys_rst_req_o && n < 2000) begin @(negedge clk); n++; end
        chk("R5 stage2 gap", n, 6 * T_FAST);
        n = 0;
        while (sys_rst_req_o && n < 100) begin @(negedge clk); n++; end
        chk("R6 pulse length", n, 16);
        wr(5'h10, 32'h0);
        rd(5'h0C, v); chk("R6 flag set", v, 32'h200);
        rd(5'h08, v); chk("R5 status set", v, 1);
    endtask

    task automatic t_clear;
        logic [31:0] v;
        unlocked_wr(5'h0C, 32'h200);
        rd(5'h0C, v); chk("R7 bit9 alone", v, 32'h200);
        unlocked_wr(5'h0C, 32'h300);
        rd(5'h0C, v); chk("R7 cleared", v, 0);
        wr(5'h08, 32'h1);
        rd(5'h08, v); chk("R11 status w1c", v, 0);
    endtask

    task automatic t_keepalive;
        logic [31:0] v;
        int i0, r0;
        i0 = irq_hi; r0 = rst_hi;
        unlocked_wr(5'h0C, 32'h100);
        wr(5'h10, 32'h2);
        repeat (12) begin
            repeat (10) @(negedge clk);
            unlocked_wr(5'h0C, 32'h100);
        end
        wr(5'h10, 32'h0);
        chk("R4 keepalive no irq", irq_hi - i0, 0);
        chk("R4 keepalive no reset", rst_hi - r0, 0);
        rd(5'h08, v); chk("R4 status clear", v, 0);
    endtask

    task automatic t_irq_kinds;
        logic [31:0] v;
        int n, r0, i0;
        wr(5'h14, 32'h05);
        unlocked_wr(5'h0C, 32'h100);
        r0 = rst_hi;
        wr(5'h10, 32'h2);
        wait_irq(n);
        @(negedge clk);
        chk("R11 pulse one cycle", irq_o, 0);
        repeat (60) @(negedge clk);
        rd(5'h0C, v); chk("R6 flag without request", v, 32'h200);
        chk("R6 request gated", rst_hi - r0, 0);
        wr(5'h10, 32'h0);
        wr(5'h14, 32'h07);
        wr(5'h08, 32'h1);
        unlocked_wr(5'h0C, 32'h300);
        i0 = irq_hi;
        wr(5'h10, 32'h2);
        repeat (45) @(negedge clk);
        wr(5'h10, 32'h0);
        rd(5'h08, v); chk("R11 none status set", v, 1);
        chk("R11 none quiet", irq_hi - i0, 0);
    endtask

    task automatic t_timer(input logic [31:0] cfg, input int period, input string tag);
        logic [31:0] v;
        int n, r0;
        wr(5'h10, 32'h0);
        wr(5'h14, cfg);
        wr(5'h08, 32'h1);
        unlocked_wr(5'h0C, 32'h300);
        r0 = rst_hi;
        wr(5'h10, 32'h6);
        wait_irq(n);
        @(negedge clk);
        n = 1;
        while (!irq_o && n < 2000) begin @(negedge clk); n++; end
        chk(tag, n, period);
        repeat (100) @(negedge clk);
        rd(5'h18, v); chk("R12 stays stage1", v[31], 0);
        rd(5'h0C, v); chk("R12 no timeout", v, 0);
        chk("R12 no request", rst_hi - r0, 0);
    endtask

    task automatic t_lock;
        logic [31:0] v;
        wr(5'h10, 32'h3);
        rd(5'h10, v); chk("R8 locked on", v, 3);
        wr(5'h10, 32'h0);
        rd(5'h10, v); chk("R8 lock and enable kept", v, 3);
    endtask

    task automatic finish_run;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_guard();
        t_reload_hold();
        t_chain();
        t_clear();
        t_keepalive();
        t_irq_kinds();
        t_timer(32'h05, 4 * T_FAST, "R12 R10 fast period");
        t_timer(32'h01, 4 * T_SLOW, "R10 slow period");
        t_lock();
        finish_run();
    end
endmodule